// File: doc/BRIEF.md
# Command and Response Transfer Engine

This block runs the byte-wide command and response exchange between a host and a command-processing backend. The host pushes a command into a shared buffer one byte per FIFO write. The block reads the big-endian 32-bit length carried in bytes 2 to 5 of the command and uses it to tell when the command is complete. When the host then issues a go request, the block hands the buffer to the backend with a start pulse. The backend writes its response into the same buffer and reports completion with a done pulse. The host then drains the response one byte per FIFO read.

A status word reports the transfer flags and a burst count. The burst count is the number of response bytes left while a response is available, and the free buffer space otherwise. The host can abort a transfer, rewind a response for a second read, and return to the ready state. Every host strobe is qualified by `loc_active`, which says whether the access comes from the locality that currently owns the interface. Single-cycle event pulses announce command-ready, status-valid and data-available transitions to an interrupt stage outside the block.

Top module: `cmdrsp_engine`

## Requirements
- R1: After reset the phase is idle, `status` is 0x00, and a word status read returns 0x00100000, which is a burst count of 4096 free bytes in bits 23:8 with the flags in bits 7:0.
- R2: A status write is first masked to bits 6 (command-ready), 5 (go) and 1 (retry). It acts only when exactly one of those bits remains; a write with two or more of them set, or with none, has no effect.
- R3: Command-ready written in idle moves the block to ready, sets `status` to 0x40 and pulses `ev_cmd_ready`. Written in ready, it changes no flag and raises no event.
- R4: The first FIFO byte written in ready moves the block to reception with `status` 0x88 (expect bit 3 and valid bit 7). FIFO writes in idle, execution or completion are dropped and leave the free-space count unchanged.
- R5: Each byte written while expect is set is stored at the next buffer position. Once more than 5 bytes are held, bytes 2 to 5 are taken as a big-endian length, and expect clears (`status` 0x80) on the byte that brings the count up to that length.
- R6: A byte written while expect is set and the buffer is already full is not stored; expect clears instead.
- R7: Go written in reception with expect clear pulses `be_start` for one cycle and enters execution. Go written in any other case is ignored.
- R8: A `be_done` pulse in execution sets `status` to 0x90 (valid plus data-available bit 4), enters completion, and pulses both `ev_data_avail` and `ev_sts_valid`.
- R9: Each FIFO read in completion with data-available set returns the next response byte. The read that takes the last byte (length from response bytes 2 to 5) sets `status` to 0x80 and pulses `ev_sts_valid`. A FIFO read with no data available returns 0xFF.
- R10: Retry written in completion rewinds the response to its first byte and restores `status` 0x90.
- R11: The burst count is the number of response bytes left while data-available is set, and the free buffer space otherwise. On a byte-wide status read the free space is capped at 255.
- R12: Command-ready written in completion moves the block to ready with `status` 0x40 and pulses `ev_cmd_ready`.
- R13: An abort, requested either by `abort_req` or by command-ready written in reception or execution, returns the block to ready with `status` 0x40 and empty offsets. Outside execution, `abort_ack` rises in the same cycle as the request. In execution, `be_cancel` is held until `be_done`, and `abort_ack` pulses in the cycle after it.
- R14: When `loc_active` is low, status and FIFO reads return 0xFFFFFFFF and all status and FIFO writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_active | input | 1 | The current access comes from the owning locality |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write value |
| sts_rd | input | 1 | Status read strobe |
| sts_rd_byte | input | 1 | The status read is byte wide |
| fifo_wr | input | 1 | FIFO write strobe |
| fifo_wdata | input | 8 | FIFO write byte |
| fifo_rd | input | 1 | FIFO read strobe |
| rdata | output | 32 | Read data, valid the cycle after a read strobe |
| status | output | 8 | Current status flags |
| abort_req | input | 1 | Abort request |
| abort_ack | output | 1 | Abort completed |
| ev_cmd_ready | output | 1 | Command-ready event pulse |
| ev_sts_valid | output | 1 | Status-valid event pulse |
| ev_data_avail | output | 1 | Data-available event pulse |
| be_start | output | 1 | Backend start pulse |
| be_cancel | output | 1 | Backend cancel request |
| be_done | input | 1 | Backend done pulse |
| be_raddr | input | 12 | Backend buffer read address |
| be_rdata | output | 8 | Backend buffer read byte |
| be_wr | input | 1 | Backend buffer write strobe |
| be_waddr | input | 12 | Backend buffer write address |
| be_wdata | input | 8 | Backend buffer write byte |

## Verification
Random commands with random lengths and payloads show that completion is taken from the embedded length rather than from a fixed count. Random response lengths, some read straight through and some with a retry part-way, separate a correct rewind and burst count from an off-by-one at the last byte. Directed cases separate the rule sets that stray writes might mix up: strobes with several control bits set, go sent before the command is complete, FIFO writes in the wrong phase, a buffer overflowing with a huge length field, accesses from a locality that does not own the interface, and aborts in reception versus execution.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READY = 3'd1,
    PH_RECV  = 3'd2,
    PH_EXEC  = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  // status flag positions
  localparam int B_VALID  = 7;
  localparam int B_CRDY   = 6;
  localparam int B_AVAIL  = 4;
  localparam int B_EXPECT = 3;

  localparam logic [7:0] CTL_MASK  = 8'h62;
  localparam logic [7:0] ST_CRDY   = 8'h40;
  localparam logic [7:0] ST_GO     = 8'h20;
  localparam logic [7:0] ST_RETRY  = 8'h02;
  localparam logic [7:0] ST_VALID  = 8'h80;
  localparam logic [7:0] ST_AVAIL  = 8'h10;
  localparam logic [7:0] ST_EXPECT = 8'h08;

  // byte 2 is most significant, byte 5 least
  function automatic logic [31:0] len_merge(input logic [31:0] cur,
                                            input logic [31:0] idx,
                                            input logic [7:0]  b);
    logic [31:0] r;
    r = cur;
    case (idx)
      32'd2:   r[31:24] = b;
      32'd3:   r[23:16] = b;
      32'd4:   r[15:8]  = b;
      32'd5:   r[7:0]   = b;
      default: r = cur;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] burst_of(input logic        avail,
                                           input logic [31:0] rsp_len,
                                           input logic [31:0] rd_off,
                                           input logic [31:0] free,
                                           input logic        narrow);
    logic [31:0] r;
    if (avail) begin
      r = rsp_len - rd_off;
    end else begin
      r = free;
      if (narrow && (r > 32'h0000_00FF)) r = 32'h0000_00FF;
    end
    return r[15:0];
  endfunction

endpackage

// File: rtl/cmdrsp_store.sv
module cmdrsp_store #(
  parameter int DEPTH = 4096,
  parameter int DW    = 8,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/cmdrsp_burst.sv
module cmdrsp_burst
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int OW   = $clog2(DEPTH) + 1
) (
  input  logic          avail,
  input  logic [31:0]   rsp_len,
  input  logic [OW-1:0] rd_off,
  input  logic [OW-1:0] wr_off,
  input  logic          narrow,
  output logic [15:0]   burst
);

  logic [31:0] free_w;

  assign free_w = 32'(DEPTH) - 32'(wr_off);
  assign burst  = burst_of(avail, rsp_len, 32'(rd_off), free_w, narrow);

endmodule

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ok,
  input  logic          sts_wr,
  input  logic [7:0]    sts_wdata,
  input  logic          fifo_wr,
  input  logic [7:0]    fifo_wdata,
  input  logic          fifo_rd,
  input  logic          abort_req,
  input  logic          be_done,
  input  logic          be_wr,
  input  logic [AW-1:0] be_waddr,
  input  logic [7:0]    be_wdata,
  input  logic [7:0]    mem_rbyte,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] rd_idx,
  output logic [7:0]    fifo_byte,
  output logic [7:0]    sts_q,
  output logic [OW-1:0] wr_off_q,
  output logic [OW-1:0] rd_off_q,
  output logic [31:0]   rsp_len_q,
  output logic          be_start,
  output logic          be_cancel,
  output logic          abort_ack,
  output logic          ev_cmd_ready,
  output logic          ev_sts_valid,
  output logic          ev_data_avail
);

  phase_e      phase_q, phase_n;
  logic [7:0]  sts_n;
  logic [OW-1:0] wr_n, rd_n;
  logic [31:0] cmd_len_q, cmd_len_n, rsp_len_n;
  logic        abort_q, abort_n;
  logic        start_n, evcr_n, evsv_n, evda_n, ackq_n, ack_q;

  // named internal events
  logic [7:0]  ctl_w;
  logic        go_abort;
  logic        host_store;
  logic        be_store;
  logic        finish_abort;
  logic        resp_arrive;

  assign ctl_w      = sts_wdata & CTL_MASK;
  assign be_store   = be_wr && (phase_q == PH_EXEC);
  assign rd_idx     = rd_off_q[AW-1:0];
  assign fifo_byte  = (host_ok && (phase_q == PH_DONE) && sts_q[B_AVAIL]) ? mem_rbyte : 8'hFF;
  assign be_cancel  = abort_q;
  assign abort_ack  = (abort_req && ((phase_q != PH_EXEC) || be_done)) || ack_q;

  always_comb begin
    logic [7:0] s;
    phase_n      = phase_q;
    sts_n        = sts_q;
    wr_n         = wr_off_q;
    rd_n         = rd_off_q;
    cmd_len_n    = cmd_len_q;
    rsp_len_n    = rsp_len_q;
    abort_n      = abort_q;
    start_n      = 1'b0;
    evcr_n       = 1'b0;
    evsv_n       = 1'b0;
    evda_n       = 1'b0;
    ackq_n       = 1'b0;
    go_abort     = 1'b0;
    host_store   = 1'b0;
    finish_abort = 1'b0;
    resp_arrive  = 1'b0;
    s            = sts_q;

    if (abort_req) begin
      go_abort = 1'b1;
    end else if (host_ok && sts_wr) begin
      case (ctl_w)
        ST_CRDY: begin
          case (phase_q)
            PH_IDLE: begin
              phase_n = PH_READY;
              sts_n   = ST_CRDY;
              evcr_n  = 1'b1;
            end
            PH_READY: begin
              wr_n = '0;
              rd_n = '0;
            end
            PH_RECV, PH_EXEC: go_abort = 1'b1;
            PH_DONE: begin
              wr_n    = '0;
              rd_n    = '0;
              phase_n = PH_READY;
              s       = sts_q;
              if (!sts_q[B_CRDY]) begin
                s      = ST_CRDY;
                evcr_n = 1'b1;
              end
              s[B_AVAIL] = 1'b0;
              sts_n      = s;
            end
            default: phase_n = phase_q;
          endcase
        end
        ST_GO: begin
          if ((phase_q == PH_RECV) && !sts_q[B_EXPECT]) begin
            start_n = 1'b1;
            phase_n = PH_EXEC;
          end
        end
        ST_RETRY: begin
          if (phase_q == PH_DONE) begin
            rd_n  = '0;
            sts_n = ST_VALID | ST_AVAIL;
          end
        end
        default: phase_n = phase_q;
      endcase
    end else if (host_ok && fifo_wr && ((phase_q == PH_READY) || (phase_q == PH_RECV))) begin
      s = sts_q;
      if (phase_q == PH_READY) begin
        phase_n = PH_RECV;
        s       = ST_EXPECT | ST_VALID;
      end
      if (s[B_EXPECT]) begin
        if (wr_off_q < OW'(DEPTH)) begin
          host_store = 1'b1;
          wr_n       = wr_off_q + 1'b1;
          cmd_len_n  = len_merge(cmd_len_q, 32'(wr_off_q), fifo_wdata);
        end else begin
          s = ST_VALID;
        end
      end
      if ((32'(wr_n) > 32'd5) && s[B_EXPECT]) begin
        evsv_n = !s[B_VALID];
        s      = (cmd_len_n > 32'(wr_n)) ? (ST_EXPECT | ST_VALID) : ST_VALID;
      end
      sts_n = s;
    end else if (host_ok && fifo_rd && (phase_q == PH_DONE) && sts_q[B_AVAIL]) begin
      rd_n = rd_off_q + 1'b1;
      if (32'(rd_n) >= rsp_len_q) begin
        sts_n  = ST_VALID;
        evsv_n = 1'b1;
      end
    end

    if (be_store && (32'(be_waddr) >= 32'd2) && (32'(be_waddr) <= 32'd5)) begin
      rsp_len_n = len_merge(rsp_len_q, 32'(be_waddr), be_wdata);
    end

    if ((phase_q == PH_EXEC) && be_done) begin
      if (abort_q || go_abort) begin
        finish_abort = 1'b1;
        ackq_n       = abort_q;
      end else begin
        resp_arrive = 1'b1;
      end
    end else if (go_abort) begin
      if (phase_q == PH_EXEC) abort_n = 1'b1;
      else                    finish_abort = 1'b1;
    end

    if (resp_arrive) begin
      sts_n   = ST_VALID | ST_AVAIL;
      phase_n = PH_DONE;
      wr_n    = '0;
      rd_n    = '0;
      evda_n  = 1'b1;
      evsv_n  = 1'b1;
    end

    if (finish_abort) begin
      phase_n = PH_READY;
      sts_n   = ST_CRDY;
      wr_n    = '0;
      rd_n    = '0;
      evcr_n  = 1'b1;
      abort_n = 1'b0;
    end
  end

  always_comb begin
    mem_we    = host_store | be_store;
    mem_waddr = host_store ? wr_off_q[AW-1:0] : be_waddr;
    mem_wdata = host_store ? fifo_wdata : be_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q       <= PH_IDLE;
      sts_q         <= '0;
      wr_off_q      <= '0;
      rd_off_q      <= '0;
      cmd_len_q     <= '0;
      rsp_len_q     <= '0;
      abort_q       <= 1'b0;
      ack_q         <= 1'b0;
      be_start      <= 1'b0;
      ev_cmd_ready  <= 1'b0;
      ev_sts_valid  <= 1'b0;
      ev_data_avail <= 1'b0;
    end else begin
      phase_q       <= phase_n;
      sts_q         <= sts_n;
      wr_off_q      <= wr_n;
      rd_off_q      <= rd_n;
      cmd_len_q     <= cmd_len_n;
      rsp_len_q     <= rsp_len_n;
      abort_q       <= abort_n;
      ack_q         <= ackq_n;
      be_start      <= start_n;
      ev_cmd_ready  <= evcr_n;
      ev_sts_valid  <= evsv_n;
      ev_data_avail <= evda_n;
    end
  end

  // cancel is only ever held during execution
  assert_cancel_in_exec_R13: assert property (@(posedge clk) disable iff (!rst_n)
    be_cancel |-> (phase_q == PH_EXEC));

  // a start pulse coincides with the execution phase
  assert_start_enters_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> (phase_q == PH_EXEC) && !be_cancel);

  // data-available only in completion
  assert_avail_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[B_AVAIL] |-> (phase_q == PH_DONE));

  // expect only while receiving
  assert_expect_in_recv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[B_EXPECT] |-> (phase_q == PH_RECV));

  // write offset never passes the buffer size
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off_q <= OW'(DEPTH));

  // done always leaves execution
  assert_done_leaves_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_EXEC) && be_done) |=> (phase_q != PH_EXEC));

  // dropped FIFO writes leave the write offset alone
  assert_fifo_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !sts_wr && !abort_req && !be_done &&
     ((phase_q == PH_IDLE) || (phase_q == PH_EXEC) || (phase_q == PH_DONE)))
    |=> $stable(wr_off_q));

endmodule

// File: rtl/cmdrsp_engine.sv
module cmdrsp_engine
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_active,
  input  logic          sts_wr,
  input  logic [7:0]    sts_wdata,
  input  logic          sts_rd,
  input  logic          sts_rd_byte,
  input  logic          fifo_wr,
  input  logic [7:0]    fifo_wdata,
  input  logic          fifo_rd,
  output logic [31:0]   rdata,
  output logic [7:0]    status,
  input  logic          abort_req,
  output logic          abort_ack,
  output logic          ev_cmd_ready,
  output logic          ev_sts_valid,
  output logic          ev_data_avail,
  output logic          be_start,
  output logic          be_cancel,
  input  logic          be_done,
  input  logic [AW-1:0] be_raddr,
  output logic [7:0]    be_rdata,
  input  logic          be_wr,
  input  logic [AW-1:0] be_waddr,
  input  logic [7:0]    be_wdata
);

  logic          mem_we;
  logic [AW-1:0] mem_waddr, rd_idx;
  logic [7:0]    mem_wdata, fifo_byte;
  logic [1:0][AW-1:0] raddr_w;
  logic [1:0][7:0]    rbyte_w;
  logic [OW-1:0] wr_off, rd_off;
  logic [31:0]   rsp_len;
  logic [15:0]   burst;

  assign raddr_w[0] = rd_idx;
  assign raddr_w[1] = be_raddr;
  assign be_rdata   = rbyte_w[1];

  cmdrsp_store #(.DEPTH(DEPTH), .DW(8), .NRD(2)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (raddr_w),
    .rdata (rbyte_w)
  );

  cmdrsp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ok      (loc_active),
    .sts_wr       (sts_wr),
    .sts_wdata    (sts_wdata),
    .fifo_wr      (fifo_wr),
    .fifo_wdata   (fifo_wdata),
    .fifo_rd      (fifo_rd),
    .abort_req    (abort_req),
    .be_done      (be_done),
    .be_wr        (be_wr),
    .be_waddr     (be_waddr),
    .be_wdata     (be_wdata),
    .mem_rbyte    (rbyte_w[0]),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata),
    .rd_idx       (rd_idx),
    .fifo_byte    (fifo_byte),
    .sts_q        (status),
    .wr_off_q     (wr_off),
    .rd_off_q     (rd_off),
    .rsp_len_q    (rsp_len),
    .be_start     (be_start),
    .be_cancel    (be_cancel),
    .abort_ack    (abort_ack),
    .ev_cmd_ready (ev_cmd_ready),
    .ev_sts_valid (ev_sts_valid),
    .ev_data_avail(ev_data_avail)
  );

  cmdrsp_burst #(.DEPTH(DEPTH)) u_burst (
    .avail   (status[B_AVAIL]),
    .rsp_len (rsp_len),
    .rd_off  (rd_off),
    .wr_off  (wr_off),
    .narrow  (sts_rd_byte),
    .burst   (burst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (sts_rd) begin
      rdata <= loc_active ? {8'h00, burst, status} : 32'hFFFF_FFFF;
    end else if (fifo_rd) begin
      rdata <= loc_active ? {24'h0, fifo_byte} : 32'hFFFF_FFFF;
    end
  end

  // reads from a non-owning locality return all ones
  assert_inactive_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_rd || fifo_rd) && !loc_active) |=> (rdata == 32'hFFFF_FFFF));

  // a byte-wide status read with no response never reports more than 255
  assert_byte_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && sts_rd_byte && loc_active && !status[B_AVAIL]) |=> (rdata[23:16] == 8'h00));

endmodule

// File: tb/cmdrsp_engine_tb.sv
module cmdrsp_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_active = 1'b1;
  logic sts_wr = 1'b0, sts_rd = 1'b0, sts_rd_byte = 1'b0;
  logic fifo_wr = 1'b0, fifo_rd = 1'b0;
  logic [7:0] sts_wdata = '0, fifo_wdata = '0;
  logic [31:0] rdata;
  logic [7:0] status;
  logic abort_req = 1'b0, abort_ack;
  logic ev_cmd_ready, ev_sts_valid, ev_data_avail;
  logic be_start, be_cancel;
  logic be_done = 1'b0, be_wr = 1'b0;
  logic [AW-1:0] be_raddr = '0, be_waddr = '0;
  logic [7:0] be_rdata, be_wdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdrsp_engine #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected status word, computed from the requirement text
  function automatic logic [31:0] exp_word(input logic [7:0] st, input int left, input bit byte_rd);
    int b;
    b = left;
    if (byte_rd && !st[4] && b > 255) b = 255;
    return {8'h00, 16'(b), st};
  endfunction

  function automatic logic [7:0] rsp_byte(input int i, input int len, input int seed);
    case (i)
      2: return 8'(len >> 24);
      3: return 8'(len >> 16);
      4: return 8'(len >> 8);
      5: return 8'(len);
      default: return 8'((i * 37 + seed) & 8'hFF);
    endcase
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_sts(input logic [7:0] v);
    sts_wr = 1'b1; sts_wdata = v; cyc(); sts_wr = 1'b0;
  endtask

  task automatic wr_fifo(input logic [7:0] v);
    fifo_wr = 1'b1; fifo_wdata = v; cyc(); fifo_wr = 1'b0;
  endtask

  task automatic rd_sts(input bit byte_rd, output logic [31:0] v);
    sts_rd = 1'b1; sts_rd_byte = byte_rd; cyc(); sts_rd = 1'b0; sts_rd_byte = 1'b0; v = rdata;
  endtask

  task automatic rd_fifo(output logic [7:0] v);
    fifo_rd = 1'b1; cyc(); fifo_rd = 1'b0; v = rdata[7:0];
  endtask

  task automatic be_respond(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      be_wr = 1'b1; be_waddr = AW'(i); be_wdata = rsp_byte(i, len, seed); cyc();
    end
    be_wr = 1'b0;
    be_done = 1'b1; cyc(); be_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] w;
    logic [7:0] b;
    logic [7:0] cmd [64];
    int seed_v;
    seed_v = int'($urandom(32'd4242));

    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 status", 32'(status), 32'h0);
    rd_sts(0, w); chk("R1 word", w, 32'h0010_0000);

    // R14 non-owning locality
    loc_active = 1'b0;
    rd_sts(0, w); chk("R14 sts read", w, 32'hFFFF_FFFF);
    rd_fifo(b); chk("R14 fifo read", rdata, 32'hFFFF_FFFF);
    wr_sts(8'h40); chk("R14 write ignored", 32'(status), 32'h0);
    loc_active = 1'b1;

    // R4 FIFO write in idle dropped
    wr_fifo(8'h5A);
    rd_sts(0, w); chk("R4 idle drop", w, exp_word(8'h00, DEPTH, 0));

    // R2 two control bits: no effect; stray bit masked away
    wr_sts(8'h60); chk("R2 multi", 32'(status), 32'h0);
    wr_sts(8'h00); chk("R2 none", 32'(status), 32'h0);
    wr_sts(8'hC0);
    chk("R2 masked CR acts", 32'(status), 32'h40);
    chk("R3 idle->ready event", 32'(ev_cmd_ready), 32'd1);
    wr_sts(8'h40);
    chk("R3 ready no event", 32'(ev_cmd_ready), 32'd0);
    chk("R3 ready status", 32'(status), 32'h40);

    // R11 byte cap in ready
    rd_sts(1, w); chk("R11 byte cap", w, exp_word(8'h40, DEPTH, 1));
    rd_sts(0, w); chk("R11 word free", w, exp_word(8'h40, DEPTH, 0));

    for (int it = 0; it < 8; it++) begin
      int clen, rlen, sd;
      clen = 6 + int'($urandom % 40);
      rlen = 6 + int'($urandom % 30);
      sd = int'($urandom % 256);
      for (int i = 0; i < clen; i++) cmd[i] = 8'($urandom);
      cmd[2] = 8'(clen >> 24); cmd[3] = 8'(clen >> 16);
      cmd[4] = 8'(clen >> 8);  cmd[5] = 8'(clen);
      for (int i = 0; i < clen; i++) begin
        wr_fifo(cmd[i]);
        if (i == 0) chk("R4 first byte", 32'(status), 32'h88);
        if (i == 2 && it % 2 == 0) begin
          wr_sts(8'h20);
          chk("R7 go with expect", 32'(be_start), 32'd0);
          chk("R7 go ignored", 32'(status), 32'h88);
        end
        if (i < clen - 1) chk("R5 still expect", 32'(status), 32'h88);
      end
      chk("R5 length reached", 32'(status), 32'h80);
      rd_sts(0, w); chk("R11 free after cmd", w, exp_word(8'h80, DEPTH - clen, 0));
      wr_fifo(8'hEE);
      rd_sts(0, w); chk("R5 extra not stored", w, exp_word(8'h80, DEPTH - clen, 0));
      wr_sts(8'h20);
      chk("R7 start pulse", 32'(be_start), 32'd1);
      cyc();
      chk("R7 start single", 32'(be_start), 32'd0);
      for (int i = 0; i < clen; i++) begin
        be_raddr = AW'(i); #1;
        chk("R5 stored byte", 32'(be_rdata), 32'(cmd[i]));
      end
      wr_fifo(8'h11);
      rd_sts(0, w); chk("R4 exec drop", w, exp_word(8'h80, DEPTH - clen, 0));
      be_respond(rlen, sd);
      chk("R8 status", 32'(status), 32'h90);
      chk("R8 ev avail", 32'(ev_data_avail), 32'd1);
      chk("R8 ev valid", 32'(ev_sts_valid), 32'd1);
      rd_sts(0, w); chk("R11 left full", w, exp_word(8'h90, rlen, 0));
      if (it % 3 == 1) begin
        for (int i = 0; i < 3; i++) begin
          rd_fifo(b); chk("R9 byte", 32'(b), 32'(rsp_byte(i, rlen, sd)));
        end
        rd_sts(0, w); chk("R11 left part", w, exp_word(8'h90, rlen - 3, 0));
        wr_sts(8'h02);
        chk("R10 retry status", 32'(status), 32'h90);
        rd_sts(0, w); chk("R10 rewound", w, exp_word(8'h90, rlen, 0));
      end
      for (int i = 0; i < rlen; i++) begin
        rd_fifo(b); chk("R9 byte", 32'(b), 32'(rsp_byte(i, rlen, sd)));
        if (i == rlen - 1) begin
          chk("R9 last status", 32'(status), 32'h80);
          chk("R9 last event", 32'(ev_sts_valid), 32'd1);
        end else begin
          chk("R9 mid status", 32'(status), 32'h90);
        end
      end
      rd_fifo(b); chk("R9 empty read", 32'(b), 32'hFF);
      wr_fifo(8'h22);
      rd_sts(0, w); chk("R4 done drop", w, exp_word(8'h80, DEPTH, 0));
      wr_sts(8'h40);
      chk("R12 status", 32'(status), 32'h40);
      chk("R12 event", 32'(ev_cmd_ready), 32'd1);
    end

    // R13 abort in reception via abort_req
    wr_fifo(8'h01); wr_fifo(8'h02); wr_fifo(8'h03);
    abort_req = 1'b1; #1;
    chk("R13 immediate ack", 32'(abort_ack), 32'd1);
    cyc(); abort_req = 1'b0;
    chk("R13 recv status", 32'(status), 32'h40);
    rd_sts(0, w); chk("R13 offsets cleared", w, exp_word(8'h40, DEPTH, 0));

    // R13 abort in reception via command-ready
    wr_fifo(8'h01); wr_fifo(8'h02);
    wr_sts(8'h40);
    chk("R13 cr abort", 32'(status), 32'h40);
    chk("R13 cr abort event", 32'(ev_cmd_ready), 32'd1);

    // R13 abort in execution
    for (int i = 0; i < 6; i++) wr_fifo((i == 5) ? 8'd6 : 8'd0);
    chk("R5 six byte cmd", 32'(status), 32'h80);
    wr_sts(8'h20);
    abort_req = 1'b1; #1;
    chk("R13 no early ack", 32'(abort_ack), 32'd0);
    cyc(); abort_req = 1'b0;
    chk("R13 cancel held", 32'(be_cancel), 32'd1);
    cyc(); cyc();
    chk("R13 cancel still", 32'(be_cancel), 32'd1);
    be_done = 1'b1; cyc(); be_done = 1'b0;
    chk("R13 late ack", 32'(abort_ack), 32'd1);
    chk("R13 cancel drop", 32'(be_cancel), 32'd0);
    chk("R13 exec status", 32'(status), 32'h40);

    // R6 buffer full with a huge length field
    for (int i = 0; i < DEPTH; i++) wr_fifo((i >= 2 && i <= 5) ? 8'hFF : 8'(i));
    chk("R6 full still expect", 32'(status), 32'h88);
    rd_sts(0, w); chk("R6 no free", w, exp_word(8'h88, 0, 0));
    wr_fifo(8'h77);
    chk("R6 overflow clears expect", 32'(status), 32'h80);
    rd_sts(0, w); chk("R6 count held", w, exp_word(8'h80, 0, 0));

    summary();
  end

endmodule